// File: doc/BRIEF.md
# Paged Program Sequencer with Return Stack

This block produces the program counter for a core whose instructions are 16 bits wide. Each cycle it takes one decoded control bundle and the operand fields of the instruction now executing, then registers the next PC. The address space is split into 8 pages of 8192 words. A jump or call uses a 13-bit offset from the instruction. The upper three bits come from a page register that a separate set-page instruction loads beforehand.

Calls save the already-incremented PC in a 16-deep circular return stack. A normal return reloads the PC from the stack and also rebuilds the page register from the top three bits of the popped word. The no-page return reloads only the PC. The literal-return form acts like a normal return and also presents an 8-bit literal with a one-cycle write strobe for the accumulator. A skip request steps over the following instruction.

Top module: `pseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, page register, stack depth, underflow flag, write strobe and literal output all become zero.
- R2: A jump loads the PC with `{page, addr_fld}`, using the page register value held before the edge. The page register is unchanged.
- R3: A call pushes PC+1 onto the return stack and loads the PC the same way as a jump.
- R4: A normal return loads the PC with the popped word and loads the page register with bits 15:13 of that word.
- R5: A no-page return loads the PC with the popped word and leaves the page register unchanged.
- R6: A literal return behaves as in R4. In the next cycle, `w_we_o` is high for exactly one cycle and `w_data_o` shows `lit_fld`. `w_data_o` holds its value until the next literal return.
- R7: A set-page loads the page register with `page_fld` and advances the PC by one.
- R8: A skip advances the PC by two.
- R9: Only one action takes effect per cycle. The order is call, jump, literal return, normal return, no-page return, skip, set-page, and plain increment. Any action asserted at the same time as a winning action has no effect.
- R10: The stack holds 16 entries. `stk_depth_o` counts entries and saturates at 16, and `stk_full_o` is high at 16. A push onto a full stack overwrites the oldest entry.
- R11: A return of any kind on an empty stack loads the PC with 0, leaves the depth at 0, and sets the sticky `underflow_o`. For a normal or literal return, the page register becomes 0.
- R12: With no action asserted, the PC advances by one and wraps from 16'hFFFF to 0. The page register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_jump | input | 1 | Jump request |
| ctl_call | input | 1 | Call request |
| ctl_ret | input | 1 | Normal return (restores page) |
| ctl_ret_np | input | 1 | Return leaving page unchanged |
| ctl_ret_lit | input | 1 | Return with literal write |
| ctl_set_page | input | 1 | Load page register |
| ctl_skip | input | 1 | Skip next instruction |
| addr_fld | input | 13 | In-page target offset |
| page_fld | input | 3 | Page value for set-page |
| lit_fld | input | 8 | Literal for literal return |
| pc_o | output | 16 | Program counter |
| page_o | output | 3 | Page register |
| w_we_o | output | 1 | Accumulator write strobe |
| w_data_o | output | 8 | Accumulator write data |
| stk_depth_o | output | 5 | Stack occupancy |
| stk_empty_o | output | 1 | Stack empty |
| stk_full_o | output | 1 | Stack full |
| underflow_o | output | 1 | Sticky pop-from-empty flag |

## Verification
The collision that matters is a stack push against a stack pop, or a page load against a page restore. These happen when a call or set-page is asserted in the same cycle as a return. The bench drives cycles where several control lines are high together, including all of them at once. It also drives random bundles in which each line is often set. A behavioural model picks the single winning action in the stated order and predicts the PC, page, stack depth and literal outputs. The model is compared with the block on every cycle, so a losing action that leaks into the stack or the page register is seen at the ports.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int PC_W   = 16;
    localparam int OFF_W  = 13;
    localparam int PG_W   = PC_W - OFF_W;
    localparam int LIT_W  = 8;

    typedef enum logic [2:0] {
        ACT_SEQ,
        ACT_PAGE,
        ACT_SKIP,
        ACT_RET_NP,
        ACT_RET,
        ACT_RET_LIT,
        ACT_JUMP,
        ACT_CALL
    } act_e;

    typedef struct packed {
        logic call;
        logic jump;
        logic ret_lit;
        logic ret;
        logic ret_np;
        logic skip;
        logic set_page;
    } ctl_s;

    // Fixed priority: one action wins each cycle.
    function automatic act_e pick_action(ctl_s c);
        if (c.call)          return ACT_CALL;
        else if (c.jump)     return ACT_JUMP;
        else if (c.ret_lit)  return ACT_RET_LIT;
        else if (c.ret)      return ACT_RET;
        else if (c.ret_np)   return ACT_RET_NP;
        else if (c.skip)     return ACT_SKIP;
        else if (c.set_page) return ACT_PAGE;
        else                 return ACT_SEQ;
    endfunction

    function automatic logic [PC_W-1:0] form_target(logic [PG_W-1:0] pg,
                                                    logic [OFF_W-1:0] off);
        return {pg, off};
    endfunction

    function automatic logic is_return(act_e a);
        return (a == ACT_RET) || (a == ACT_RET_NP) || (a == ACT_RET_LIT);
    endfunction

endpackage

// File: rtl/pseq_stack.sv
module pseq_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 push_val,
    output logic [W-1:0]                 top_val,
    output logic [$clog2(DEPTH+1)-1:0]   depth,
    output logic                         empty,
    output logic                         full,
    output logic                         underflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             uf_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    always_comb begin
        ptr_inc = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
        ptr_dec = (ptr_q == '0) ? PTR_LAST : ptr_q - PTR_W'(1);
    end

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_MAX);
    assign depth     = cnt_q;
    assign underflow = uf_q;
    assign top_val   = empty ? '0 : mem[ptr_dec];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[ptr_q] <= push_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
            uf_q  <= 1'b0;
        end else if (push) begin
            ptr_q <= ptr_inc;
            if (!full) cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop) begin
            if (empty) begin
                uf_q <= 1'b1;
            end else begin
                ptr_q <= ptr_dec;
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // R10: occupancy never exceeds the depth
    p_depth_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R10: a push below full grows the depth by one
    p_push_grows_r10: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R10: a push on a full stack keeps it full
    p_full_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> full);

    // R11: the underflow flag is sticky
    p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        uf_q |=> uf_q);

    // R11: popping an empty stack leaves it empty
    p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> (empty && uf_q));

    // R9: push and pop never come from the same cycle
    p_one_stack_op_r9: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/pseq_nextpc.sv
module pseq_nextpc
    import pseq_pkg::*;
(
    input  act_e              act,
    input  logic [PC_W-1:0]   pc,
    input  logic [PG_W-1:0]   page,
    input  logic [OFF_W-1:0]  off,
    input  logic [PG_W-1:0]   pg_fld,
    input  logic [PC_W-1:0]   top_val,
    output logic [PC_W-1:0]   pc_n,
    output logic [PG_W-1:0]   page_n,
    output logic              push,
    output logic              pop,
    output logic [PC_W-1:0]   push_val,
    output logic              w_we_n
);
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] target;

    assign pc_inc   = pc + PC_W'(1);
    assign target   = form_target(page, off);
    assign push_val = pc_inc;

    always_comb begin
        pc_n   = pc_inc;
        page_n = page;
        push   = 1'b0;
        pop    = 1'b0;
        w_we_n = 1'b0;
        unique case (act)
            ACT_CALL: begin
                push = 1'b1;
                pc_n = target;
            end
            ACT_JUMP: pc_n = target;
            ACT_RET_LIT: begin
                pop    = 1'b1;
                pc_n   = top_val;
                page_n = top_val[PC_W-1:OFF_W];
                w_we_n = 1'b1;
            end
            ACT_RET: begin
                pop    = 1'b1;
                pc_n   = top_val;
                page_n = top_val[PC_W-1:OFF_W];
            end
            ACT_RET_NP: begin
                pop  = 1'b1;
                pc_n = top_val;
            end
            ACT_SKIP: pc_n = pc + PC_W'(2);
            ACT_PAGE: page_n = pg_fld;
            default:  pc_n = pc_inc;
        endcase
    end

endmodule

// File: rtl/pseq_top.sv
module pseq_top
    import pseq_pkg::*;
#(
    parameter int STK_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ctl_jump,
    input  logic                          ctl_call,
    input  logic                          ctl_ret,
    input  logic                          ctl_ret_np,
    input  logic                          ctl_ret_lit,
    input  logic                          ctl_set_page,
    input  logic                          ctl_skip,
    input  logic [12:0]                   addr_fld,
    input  logic [2:0]                    page_fld,
    input  logic [7:0]                    lit_fld,
    output logic [15:0]                   pc_o,
    output logic [2:0]                    page_o,
    output logic                          w_we_o,
    output logic [7:0]                    w_data_o,
    output logic [$clog2(STK_DEPTH+1)-1:0] stk_depth_o,
    output logic                          stk_empty_o,
    output logic                          stk_full_o,
    output logic                          underflow_o
);
    ctl_s             ctl;
    act_e             act;
    logic [PC_W-1:0]  pc_q, pc_n;
    logic [PG_W-1:0]  page_q, page_n;
    logic             w_we_q, w_we_n;
    logic [LIT_W-1:0] w_data_q;
    logic             push, pop;
    logic [PC_W-1:0]  push_val, top_val;

    assign ctl = '{call: ctl_call, jump: ctl_jump, ret_lit: ctl_ret_lit,
                   ret: ctl_ret, ret_np: ctl_ret_np, skip: ctl_skip,
                   set_page: ctl_set_page};
    assign act = pick_action(ctl);

    pseq_nextpc u_next (
        .act      (act),
        .pc       (pc_q),
        .page     (page_q),
        .off      (addr_fld),
        .pg_fld   (page_fld),
        .top_val  (top_val),
        .pc_n     (pc_n),
        .page_n   (page_n),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .w_we_n   (w_we_n)
    );

    pseq_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_val  (push_val),
        .top_val   (top_val),
        .depth     (stk_depth_o),
        .empty     (stk_empty_o),
        .full      (stk_full_o),
        .underflow (underflow_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            page_q   <= '0;
            w_we_q   <= 1'b0;
            w_data_q <= '0;
        end else begin
            pc_q   <= pc_n;
            page_q <= page_n;
            w_we_q <= w_we_n;
            if (w_we_n) w_data_q <= lit_fld;
        end
    end

    assign pc_o     = pc_q;
    assign page_o   = page_q;
    assign w_we_o   = w_we_q;
    assign w_data_o = w_data_q;

    // R8: a lone skip advances by two
    p_skip_step_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_skip && !ctl_call && !ctl_jump && !ctl_ret && !ctl_ret_np && !ctl_ret_lit)
        |=> (pc_q == $past(pc_q) + 16'd2));

    // R5: a winning no-page return keeps the page
    p_np_keeps_page_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_ret_np && !ctl_call && !ctl_jump && !ctl_ret && !ctl_ret_lit)
        |=> $stable(page_q));

    // R2: a jump keeps the page and lands on the given offset
    p_jump_target_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_jump && !ctl_call) |=> ($stable(page_q) && pc_q[12:0] == $past(addr_fld)));

    // R6: the write strobe lasts one cycle
    p_wstrobe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (w_we_q && !$past(ctl_ret_lit && !ctl_call && !ctl_jump)) |-> 1'b0);

    // R12: a cycle with no action steps the PC by one
    p_seq_step_r12: assert property (@(posedge clk) disable iff (rst)
        !(ctl_call || ctl_jump || ctl_ret || ctl_ret_np || ctl_ret_lit || ctl_skip)
        |=> (pc_q == $past(pc_q) + 16'd1));

endmodule

// File: tb/pseq_top_tb.sv
`timescale 1ns/1ps
module pseq_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_jump = 0, c_call = 0, c_ret = 0, c_rnp = 0, c_rlit = 0, c_pg = 0, c_skip = 0;
    logic [12:0] a_fld = '0;
    logic [2:0]  p_fld = '0;
    logic [7:0]  l_fld = '0;
    logic [15:0] pc;
    logic [2:0]  page;
    logic        wwe;
    logic [7:0]  wdata;
    logic [4:0]  depth;
    logic        empty, full, uflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [15:0] m_pc = 0;
    logic [2:0]  m_page = 0;
    logic [15:0] m_stk[$];
    logic        m_uf = 0;
    logic        m_wwe = 0;
    logic [7:0]  m_wdata = 0;

    always #2 clk = ~clk;

    pseq_top u_dut (
        .clk(clk), .rst(rst),
        .ctl_jump(c_jump), .ctl_call(c_call), .ctl_ret(c_ret),
        .ctl_ret_np(c_rnp), .ctl_ret_lit(c_rlit), .ctl_set_page(c_pg),
        .ctl_skip(c_skip), .addr_fld(a_fld), .page_fld(p_fld), .lit_fld(l_fld),
        .pc_o(pc), .page_o(page), .w_we_o(wwe), .w_data_o(wdata),
        .stk_depth_o(depth), .stk_empty_o(empty), .stk_full_o(full),
        .underflow_o(uflow)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag,   "pc",    pc, m_pc);
        chk(tag,   "page",  16'(page), 16'(m_page));
        chk("R10", "depth", 16'(depth), 16'(m_stk.size()));
        chk("R10", "full",  16'(full), 16'(m_stk.size() == 16));
        chk("R10", "empty", 16'(empty), 16'(m_stk.size() == 0));
        chk("R11", "underflow", 16'(uflow), 16'(m_uf));
        chk("R6",  "w_we",  16'(wwe), 16'(m_wwe));
        chk("R6",  "w_data", 16'(wdata), 16'(m_wdata));
    endtask

    // one instruction cycle: drive, predict, clock, compare
    task automatic step(bit j, bit c, bit r, bit rn, bit rl, bit sp, bit sk,
                        logic [12:0] a, logic [2:0] p, logic [7:0] l, string force_tag);
        string tag;
        logic [15:0] v;
        c_jump = j; c_call = c; c_ret = r; c_rnp = rn; c_rlit = rl;
        c_pg = sp; c_skip = sk; a_fld = a; p_fld = p; l_fld = l;
        m_wwe = 0;
        if (c) begin
            tag = "R3";
            m_stk.push_back(m_pc + 16'd1);
            if (m_stk.size() > 16) void'(m_stk.pop_front());
            m_pc = {m_page, a};
        end else if (j) begin
            tag = "R2";
            m_pc = {m_page, a};
        end else if (rl || r || rn) begin
            tag = rl ? "R6" : (r ? "R4" : "R5");
            if (m_stk.size() == 0) begin
                v = 16'd0;
                m_uf = 1;
                tag = "R11";
            end else begin
                v = m_stk.pop_back();
            end
            m_pc = v;
            if (rl || r) m_page = v[15:13];
            if (rl) begin
                m_wwe = 1;
                m_wdata = l;
            end
        end else if (sk) begin
            tag = "R8";
            m_pc = m_pc + 16'd2;
        end else if (sp) begin
            tag = "R7";
            m_page = p;
            m_pc = m_pc + 16'd1;
        end else begin
            tag = "R12";
            m_pc = m_pc + 16'd1;
        end
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle();
        step(0,0,0,0,0,0,0, 13'h0, 3'h0, 8'h0, "");
    endtask

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_all("R1");                       // R1: reset state

        repeat (3) idle();                       // R12: sequential
        step(0,0,0,0,0,1,0, 13'h0, 3'h5, 8'h0, "");      // R7 set page 5
        step(1,0,0,0,0,0,0, 13'h0123, 3'h0, 8'h0, "");   // R2 jump -> A123
        step(0,1,0,0,0,0,0, 13'h1F00, 3'h0, 8'h0, "");   // R3 call
        step(0,0,0,0,0,0,1, 13'h0, 3'h0, 8'h0, "");      // R8 skip
        step(0,0,0,0,0,1,0, 13'h0, 3'h2, 8'h0, "");      // page 2
        step(0,0,1,0,0,0,0, 13'h0, 3'h0, 8'h0, "");      // R4 restores page 5
        step(0,0,0,0,0,1,0, 13'h0, 3'h1, 8'h0, "");
        step(0,1,0,0,0,0,0, 13'h0042, 3'h0, 8'h0, "");
        step(0,0,0,0,0,1,0, 13'h0, 3'h6, 8'h0, "");
        step(0,0,0,1,0,0,0, 13'h0, 3'h0, 8'h0, "");      // R5 page stays 6
        step(0,1,0,0,0,0,0, 13'h0777, 3'h0, 8'h0, "");
        step(0,0,0,0,1,0,0, 13'h0, 3'h0, 8'hA5, "");     // R6 literal return
        idle();                                           // R6 strobe drops, data held
        // R9: everything at once, call wins
        step(1,1,1,1,1,1,1, 13'h0333, 3'h7, 8'h11, "R9");
        // R9: returns and skip together, literal return wins
        step(0,0,1,1,1,1,1, 13'h0, 3'h7, 8'h5A, "R9");
        // R9: skip over set-page
        step(0,0,0,0,0,1,1, 13'h0, 3'h4, 8'h0, "R9");
        // R10: overfill, then drain past empty (R11)
        for (int i = 0; i < 18; i++)
            step(0,1,0,0,0,0,0, 13'(i * 37), 3'h0, 8'h0, "R10");
        for (int i = 0; i < 17; i++)
            step(0,0,1,0,0,0,0, 13'h0, 3'h0, 8'h0, "");
        step(0,0,0,1,0,0,0, 13'h0, 3'h0, 8'h0, "R11");
        // R12: wrap from FFFF
        step(0,0,0,0,0,1,0, 13'h0, 3'h7, 8'h0, "");
        step(1,0,0,0,0,0,0, 13'h1FFF, 3'h0, 8'h0, "");
        idle();
        idle();
        // random bundles
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            step(r < 8, (r >= 8 && r < 20), (r >= 20 && r < 28), (r >= 28 && r < 33),
                 (r >= 33 && r < 38), $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
                 13'($urandom), 3'($urandom), 8'($urandom), "R9");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule